// File: doc/BRIEF.md
# Fractional Audio Effects ALU

This block is the execution unit of a 32-bit fixed-point audio effects engine. Each cycle in which `in_valid` is high it takes a 4-bit opcode and three signed operands A, X and Y. One clock later it returns a result word, an updated hidden accumulator, a condition word, and a skip request. Values are treated as signed fractions: a product X*Y shifted arithmetically right by 31 bits is a fractional multiply.

The sixteen opcodes cover these functions:
- fractional multiply-accumulate, either clamped or wrapping;
- integer multiply-accumulate;
- three-input add;
- a move that loads the hidden accumulator;
- bitwise mixing;
- signed compare-and-select;
- linear interpolation;
- a conditional skip test for the sequencer that surrounds the block.

Two opcodes are reserved for log and exp conversion. Here they pass A through unchanged. The block has no instruction fetch and no register-file or delay-line access. A sequencer feeds it operands and consumes its outputs.

The datapath is a single registered stage. There is no multi-cycle control. The only state is the output register set and the accumulator.

Top module: `fxalu_core`

## Requirements
- R1: While `rst_n` is low, and directly after reset, `out_valid`, `skip_req`, `result`, `cond`, `acc_out` and `skip_count` are all zero.
- R2: Opcode 0x0 gives A + (X*Y >>> 31) and opcode 0x1 gives A - (X*Y >>> 31). Both are computed exactly and clamped to 0x7FFFFFFF or 0x80000000. When a clamp occurs, cond bit 4 is set.
- R3: Opcodes 0x2 and 0x3 compute the same sums as 0x0 and 0x1 but keep the low 32 bits. Cond bit 4 stays clear.
- R4: Opcode 0x4 gives A + X*Y (full integer product), clamped as in R2 with cond bit 4. Opcode 0x5 keeps bits 30..0 of A + X*Y and sign-extends them from bit 30.
- R5: Opcode 0x6 gives A + X + Y, clamped as in R2 with cond bit 4.
- R6: Opcode 0x7 returns A as the result and adds the low 32 bits of (X*Y >>> 31) to the accumulator, wrapping. No other opcode changes the accumulator.
- R7: Opcode 0x8 gives (A AND X) XOR Y.
- R8: The compare opcodes all use a signed comparison. Opcode 0x9 gives X if A >= Y, else NOT X. Opcode 0xA gives X if A >= Y, else Y. Opcode 0xB gives X if A < Y, else Y. On these three opcodes cond bit 1 is set exactly when A < Y.
- R9: Opcode 0xE gives A + (X*(Y-A) >>> 31), computed exactly and clamped as in R2 with cond bit 4.
- R10: Opcodes 0xC and 0xD return A unchanged.
- R11: Opcode 0xF returns A. It raises `skip_req` when (A AND Y) is nonzero, and in that case `skip_count` takes the low COUNT_W bits of X. Otherwise `skip_count` is zero.
- R12: Cond bit 0 is result[31] XOR result[30]. Bit 2 is result[31]. Bit 3 is set when the result is zero. Bit 8 is set when the result is nonzero. Bits 1 and 4 follow R8 and R2. All other cond bits are zero.
- R13: Outputs appear on the clock edge after an accepted operation, with `out_valid` high for one cycle. In a cycle with `in_valid` low, `out_valid` and `skip_req` go low and `result`, `cond`, `acc_out` and `skip_count` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select |
| op_a | input | DATA_W | Operand A |
| op_x | input | DATA_W | Operand X |
| op_y | input | DATA_W | Operand Y |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | DATA_W | Result word R |
| cond | output | DATA_W | Condition word |
| acc_out | output | DATA_W | Hidden accumulator |
| skip_req | output | 1 | Skip test passed |
| skip_count | output | COUNT_W | Number of instructions to skip |

## Verification
The assertions assume that `opcode` and the operands are known, non-X values whenever `in_valid` is high. They also assume that nothing is presented during reset. The bench drives every operand from explicit constants or from `$urandom`, and holds `in_valid` low until reset is released.

Operands are chosen so that each clamp boundary is reached from both signs. They also hit the ordering of A against Y for negative values, and both outcomes of the skip test. A stretch of random operations then checks the output on every clock.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

    typedef enum logic [3:0] {
        OP_FMAC    = 4'h0,
        OP_FMSC    = 4'h1,
        OP_FMAC_W  = 4'h2,
        OP_FMSC_W  = 4'h3,
        OP_IMAC_S  = 4'h4,
        OP_IMAC_W  = 4'h5,
        OP_ADD3    = 4'h6,
        OP_ACCMV   = 4'h7,
        OP_MIX     = 4'h8,
        OP_TSTSEL  = 4'h9,
        OP_GESEL   = 4'hA,
        OP_LTSEL   = 4'hB,
        OP_LOGP    = 4'hC,
        OP_EXPP    = 4'hD,
        OP_LERP    = 4'hE,
        OP_SKIP    = 4'hF
    } alu_op_e;

    // condition word bit positions (decoded by the skip test of later code)
    localparam int CC_NORM   = 0;
    localparam int CC_BORROW = 1;
    localparam int CC_MINUS  = 2;
    localparam int CC_ZERO   = 3;
    localparam int CC_SAT    = 4;
    localparam int CC_NZ     = 8;

    // indices into the bank of clamping units
    localparam int SI_FADD = 0;
    localparam int SI_FSUB = 1;
    localparam int SI_IMAC = 2;
    localparam int SI_ADD3 = 3;
    localparam int SI_NUM  = 4;

endpackage

// File: rtl/fxalu_sat.sv
module fxalu_sat #(
    parameter int IN_W  = 68,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0] v,
    output logic [OUT_W-1:0]       y,
    output logic                   clamped
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             fits;

    always_comb begin
        top_bits = v[IN_W-1:OUT_W-1];
        fits     = (&top_bits) | ~(|top_bits);
        clamped  = ~fits;
        if (fits)
            y = v[OUT_W-1:0];
        else if (v[IN_W-1])
            y = {1'b1, {(OUT_W-1){1'b0}}};
        else
            y = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/fxalu_arith.sv
module fxalu_arith
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e                  op,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] y,
    output logic [DATA_W-1:0]        res,
    output logic                     sat,
    output logic [DATA_W-1:0]        acc_inc
);
    localparam int FS = DATA_W - 1;
    localparam int PW = 2 * DATA_W;
    localparam int EW = PW + 4;
    localparam int LW = PW + 8;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] frac;
    logic signed [EW-1:0] a_e, x_e, y_e, frac_e, prod_e;
    logic signed [EW-1:0] fsum, fdiff, isum, tsum;
    logic signed [LW-1:0] a_l, x_l, y_l, d_l, lprod, lsum;

    logic signed [EW-1:0] sat_in  [SI_NUM];
    logic [DATA_W-1:0]    sat_out [SI_NUM];
    logic                 sat_hit [SI_NUM];
    logic [DATA_W-1:0]    lerp_out;
    logic                 lerp_hit;

    always_comb begin
        prod   = $signed({{DATA_W{x[DATA_W-1]}}, x}) * $signed({{DATA_W{y[DATA_W-1]}}, y});
        frac   = prod >>> FS;
        a_e    = {{(EW-DATA_W){a[DATA_W-1]}}, a};
        x_e    = {{(EW-DATA_W){x[DATA_W-1]}}, x};
        y_e    = {{(EW-DATA_W){y[DATA_W-1]}}, y};
        frac_e = {{(EW-PW){frac[PW-1]}}, frac};
        prod_e = {{(EW-PW){prod[PW-1]}}, prod};
        fsum   = a_e + frac_e;
        fdiff  = a_e - frac_e;
        isum   = a_e + prod_e;
        tsum   = a_e + x_e + y_e;
        a_l    = {{(LW-DATA_W){a[DATA_W-1]}}, a};
        x_l    = {{(LW-DATA_W){x[DATA_W-1]}}, x};
        y_l    = {{(LW-DATA_W){y[DATA_W-1]}}, y};
        d_l    = y_l - a_l;
        lprod  = x_l * d_l;
        lsum   = a_l + (lprod >>> FS);
        sat_in[SI_FADD] = fsum;
        sat_in[SI_FSUB] = fdiff;
        sat_in[SI_IMAC] = isum;
        sat_in[SI_ADD3] = tsum;
        acc_inc = frac[DATA_W-1:0];
    end

    for (genvar g = 0; g < SI_NUM; g++) begin : g_clamp
        fxalu_sat #(.IN_W(EW), .OUT_W(DATA_W)) u_sat (
            .v       (sat_in[g]),
            .y       (sat_out[g]),
            .clamped (sat_hit[g])
        );
    end

    fxalu_sat #(.IN_W(LW), .OUT_W(DATA_W)) u_sat_lerp (
        .v       (lsum),
        .y       (lerp_out),
        .clamped (lerp_hit)
    );

    always_comb begin
        res = a;
        sat = 1'b0;
        unique case (op)
            OP_FMAC: begin
                res = sat_out[SI_FADD];
                sat = sat_hit[SI_FADD];
            end
            OP_FMSC: begin
                res = sat_out[SI_FSUB];
                sat = sat_hit[SI_FSUB];
            end
            OP_FMAC_W: res = fsum[DATA_W-1:0];
            OP_FMSC_W: res = fdiff[DATA_W-1:0];
            OP_IMAC_S: begin
                res = sat_out[SI_IMAC];
                sat = sat_hit[SI_IMAC];
            end
            OP_IMAC_W: res = {isum[DATA_W-2], isum[DATA_W-2:0]};
            OP_ADD3: begin
                res = sat_out[SI_ADD3];
                sat = sat_hit[SI_ADD3];
            end
            OP_LERP: begin
                res = lerp_out;
                sat = lerp_hit;
            end
            default: begin
                res = a;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fxalu_logic.sv
module fxalu_logic
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e                  op,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] y,
    output logic [DATA_W-1:0]        res,
    output logic                     a_lt_y
);
    always_comb begin
        a_lt_y = (a < y);
        unique case (op)
            OP_MIX:    res = (a & x) ^ y;
            OP_TSTSEL: res = a_lt_y ? ~x : x;
            OP_GESEL:  res = a_lt_y ? y : x;
            OP_LTSEL:  res = a_lt_y ? x : y;
            default:   res = a;
        endcase
    end
endmodule

// File: rtl/fxalu_flags.sv
module fxalu_flags
    import fxalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic              sat,
    input  logic              borrow,
    output logic [DATA_W-1:0] cond
);
    always_comb begin
        cond            = '0;
        cond[CC_NORM]   = res[DATA_W-1] ^ res[DATA_W-2];
        cond[CC_BORROW] = borrow;
        cond[CC_MINUS]  = res[DATA_W-1];
        cond[CC_ZERO]   = (res == '0);
        cond[CC_SAT]    = sat;
        cond[CC_NZ]     = (res != '0);
    end
endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
    import fxalu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         opcode,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_x,
    input  logic [DATA_W-1:0]  op_y,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic [DATA_W-1:0]  cond,
    output logic [DATA_W-1:0]  acc_out,
    output logic               skip_req,
    output logic [COUNT_W-1:0] skip_count
);
    alu_op_e            op;
    logic [DATA_W-1:0]  arith_res, logic_res, acc_inc, res_d, cond_d;
    logic               arith_sat, a_lt_y, is_cmp, skip_d;
    logic [COUNT_W-1:0] count_d;

    assign op = alu_op_e'(opcode);

    fxalu_arith #(.DATA_W(DATA_W)) u_arith (
        .op      (op),
        .a       (op_a),
        .x       (op_x),
        .y       (op_y),
        .res     (arith_res),
        .sat     (arith_sat),
        .acc_inc (acc_inc)
    );

    fxalu_logic #(.DATA_W(DATA_W)) u_logic (
        .op     (op),
        .a      (op_a),
        .x      (op_x),
        .y      (op_y),
        .res    (logic_res),
        .a_lt_y (a_lt_y)
    );

    always_comb begin
        is_cmp = 1'b0;
        unique case (op)
            OP_FMAC, OP_FMSC, OP_FMAC_W, OP_FMSC_W,
            OP_IMAC_S, OP_IMAC_W, OP_ADD3, OP_LERP:  res_d = arith_res;
            OP_MIX:                                  res_d = logic_res;
            OP_TSTSEL, OP_GESEL, OP_LTSEL: begin
                res_d  = logic_res;
                is_cmp = 1'b1;
            end
            default:                                 res_d = op_a;
        endcase
        skip_d  = (op == OP_SKIP) && ((op_a & op_y) != '0);
        count_d = skip_d ? op_x[COUNT_W-1:0] : '0;
    end

    fxalu_flags #(.DATA_W(DATA_W)) u_flags (
        .res    (res_d),
        .sat    (arith_sat),
        .borrow (is_cmp & a_lt_y),
        .cond   (cond_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            skip_req   <= 1'b0;
            result     <= '0;
            cond       <= '0;
            acc_out    <= '0;
            skip_count <= '0;
        end else begin
            out_valid <= in_valid;
            skip_req  <= in_valid & skip_d;
            if (in_valid) begin
                result     <= res_d;
                cond       <= cond_d;
                skip_count <= count_d;
                if (op == OP_ACCMV)
                    acc_out <= acc_out + acc_inc;
            end
        end
    end
endmodule

// File: rtl/fxalu_chk.sv
module fxalu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        opcode,
    input logic [DATA_W-1:0] op_a,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] cond,
    input logic [DATA_W-1:0] acc_out,
    input logic              skip_req
);
    localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !skip_req && $stable(result) && $stable(cond)));
    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && opcode == 4'h7) |=> $stable(acc_out));
    // R11
    skip_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> out_valid);
    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cond[3] != cond[8]));
    // R2
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond[4]) |-> (result == MAXV || result == MINV));
    // R10
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 4'hC || opcode == 4'hD)) |=> (result == $past(op_a)));
endmodule

bind fxalu_core fxalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .op_a      (op_a),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond),
    .acc_out   (acc_out),
    .skip_req  (skip_req)
);

// File: tb/fxalu_core_test.sv
module fxalu_core_test;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    opcode = '0;
    logic [31:0]   op_a = '0, op_x = '0, op_y = '0;
    logic          out_valid, skip_req;
    logic [31:0]   result, cond, acc_out;
    logic [CW-1:0] skip_count;

    int errors = 0;
    int checks = 0;

    logic [31:0]   m_acc = '0;
    logic [31:0]   m_res = '0;
    logic [31:0]   m_cond = '0;
    logic [CW-1:0] m_cnt = '0;

    always #4 clk = ~clk;

    fxalu_core #(.DATA_W(32), .COUNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_x(op_x), .op_y(op_y), .out_valid(out_valid),
        .result(result), .cond(cond), .acc_out(acc_out),
        .skip_req(skip_req), .skip_count(skip_count)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] clamp(input logic signed [127:0] v, output bit hit);
        hit = 1'b1;
        if (v > 128'sd2147483647) return 32'h7FFFFFFF;
        if (v < -128'sd2147483648) return 32'h80000000;
        hit = 1'b0;
        return v[31:0];
    endfunction

    task automatic run(input logic [3:0] op, input int a, input int x, input int y, input string req);
        logic signed [127:0] A, X, Y, p, f, t;
        logic [31:0] r;
        bit hit, bor, sk;
        A = a; X = x; Y = y;
        p = X * Y;
        f = p >>> 31;
        hit = 0; bor = 0; sk = 0;
        case (op)
            4'h0: r = clamp(A + f, hit);
            4'h1: r = clamp(A - f, hit);
            4'h2: begin t = A + f; r = t[31:0]; end
            4'h3: begin t = A - f; r = t[31:0]; end
            4'h4: r = clamp(A + p, hit);
            4'h5: begin t = A + p; r = {t[30], t[30:0]}; end
            4'h6: r = clamp(A + X + Y, hit);
            4'h7: begin r = a; m_acc = m_acc + f[31:0]; end
            4'h8: r = (a & x) ^ y;
            4'h9: begin bor = (a < y); r = bor ? ~x : x; end
            4'hA: begin bor = (a < y); r = bor ? y : x; end
            4'hB: begin bor = (a < y); r = bor ? x : y; end
            4'hE: r = clamp(A + ((X * (Y - A)) >>> 31), hit);
            4'hF: begin r = a; sk = ((a & y) != 0); end
            default: r = a;
        endcase
        m_res = r;
        m_cond = '0;
        m_cond[0] = r[31] ^ r[30];
        m_cond[1] = bor;
        m_cond[2] = r[31];
        m_cond[3] = (r == 0);
        m_cond[4] = hit;
        m_cond[8] = (r != 0);
        m_cnt = sk ? x[CW-1:0] : '0;
        opcode = op; op_a = a; op_x = x; op_y = y; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R13", "out_valid", {31'd0, out_valid}, 32'd1);
        chk(req, "result", result, m_res);
        chk(req == "R2" || req == "R8" ? req : "R12", "cond", cond, m_cond);
        chk("R6", "acc", acc_out, m_acc);
        chk("R11", "skip_req", {31'd0, skip_req}, {31'd0, sk});
        chk("R11", "skip_count", {22'd0, skip_count}, {22'd0, m_cnt});
    endtask

    task automatic idle();
        in_valid = 1'b0;
        opcode = 4'h7; op_x = 32'h7FFFFFFF; op_y = 32'h7FFFFFFF;
        @(negedge clk);
        chk("R13", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R13", "idle skip_req", {31'd0, skip_req}, 32'd0);
        chk("R13", "idle result", result, m_res);
        chk("R13", "idle cond", cond, m_cond);
        chk("R13", "idle skip_count", {22'd0, skip_count}, {22'd0, m_cnt});
        chk("R6", "idle acc", acc_out, m_acc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "reset result", result, 32'd0);
        chk("R1", "reset cond", cond, 32'd0);
        chk("R1", "reset acc", acc_out, 32'd0);
        chk("R1", "reset skip", {21'd0, skip_req, skip_count}, 32'd0);
        rst_n = 1'b1;

        run(4'h0, 32'h10000000, 32'h40000000, 32'h40000000, "R2");
        run(4'h0, 32'h7FFF0000, 32'h7FFFFFFF, 32'h7FFFFFFF, "R2");
        run(4'h1, 32'h80000100, 32'h40000000, 32'h40000000, "R2");
        run(4'h1, 32'h00001000, 32'hC0000000, 32'h40000000, "R2");
        run(4'h2, 32'h7FFF0000, 32'h7FFFFFFF, 32'h7FFFFFFF, "R3");
        run(4'h3, 32'h80000100, 32'h40000000, 32'h40000000, "R3");
        run(4'h4, 5, 3, -7, "R4");
        run(4'h4, 1, 32'h00010000, 32'h00010000, "R4");
        run(4'h4, -1, 32'h00010000, 32'hFFFF0000, "R4");
        run(4'h5, 0, 32'h00010000, 32'h00008000, "R4");
        run(4'h5, -3, 1, 1, "R4");
        run(4'h6, 100, -30, 7, "R5");
        run(4'h6, 32'h7FFFFFF0, 32'h10, 1, "R5");
        run(4'h6, 32'h80000000, -1, 0, "R5");
        run(4'h7, 32'h12345678, 32'h40000000, 32'h20000000, "R6");
        run(4'h7, 32'h00000001, 32'h80000000, 32'h40000000, "R6");
        run(4'h0, 0, 32'h40000000, 32'h40000000, "R6");
        idle();
        run(4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0F0F, "R7");
        run(4'h8, 0, 32'hFFFFFFFF, 0, "R12");
        run(4'h9, -5, 32'h0000AAAA, 3, "R8");
        run(4'h9, 3, 32'h0000AAAA, -5, "R8");
        run(4'hA, -2, 11, -2, "R8");
        run(4'hA, -9, 11, -2, "R8");
        run(4'hB, -9, 11, -2, "R8");
        run(4'hB, 4, 11, -2, "R8");
        run(4'hE, 32'h10000000, 32'h40000000, 32'h30000000, "R9");
        run(4'hE, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, "R9");
        run(4'hE, 32'h7FFFFFFF, 32'h80000000, 32'h80000000, "R9");
        run(4'hC, 32'hDEADBEEF, 1, 2, "R10");
        run(4'hD, 32'h40000000, 3, 4, "R10");
        run(4'hF, 32'h00000110, 32'h00000ABC, 32'h00000100, "R11");
        idle();
        run(4'hF, 32'h00000110, 32'h00000ABC, 32'h00000001, "R11");
        idle();
        for (int i = 0; i < 400; i++) begin
            run(4'($urandom_range(0, 15)), int'($urandom), int'($urandom), int'($urandom), "R12");
            if (i % 50 == 0) idle();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule